// File: doc/BRIEF.md
# Page-Mode Read Sequencer for Asynchronous DRAM

This block turns host read requests into the strobe and multiplexed-address sequence that an asynchronous DRAM needs. The host hands over a row, a column and a keep-open hint. The block puts the row on the shared address lines and lowers RAS. It then switches the lines to the column, lowers CAS and finally lowers OE. On the last cycle of the OE phase it samples the returned word into a holding register and reports it with a one-cycle pulse. Every phase lasts `PHASE_CYC` clock cycles. Closing a row costs `PRE_CYC` cycles with RAS high.

When the host sets the keep hint, the row stays open after the access. A following request to the same row then runs only the column, CAS and OE phases. A request to a different row first closes the open row. The `edo_mode` pin selects the extended-data-output variant: once OE has gone low it stays low while the row remains open, so the previous word is still driven while the next column cycle starts. Change `edo_mode` only while no row is open.

The request side is valid/ready. The host holds `req_valid` and the request fields steady until a clock edge where `req_ready` is also high. `req_ready` is high only when the block is idle or is holding a row open. The read-data side has no back-pressure: the host must take `rd_data` in the cycle where `rd_valid` is high.

Top module: `dram_page_rd`

## Requirements
- R1: During and right after reset, RAS, CAS, OE and WE are high (inactive), `req_ready` is high and `rd_valid` is low.
- R2: A request accepted while idle produces four phases of `PHASE_CYC` cycles each, then an OE phase. The four phases are: row on the address lines with RAS high; row with RAS low; column with RAS low and CAS high; column with CAS low and OE still high (FPM). The OE phase has the column on the lines and CAS and OE low.
- R3: WE stays high on every cycle.
- R4: `rd_data` is the value on `dram_dq` in the last cycle of the OE phase. `rd_valid` is high for exactly the one following cycle.
- R5: With keep low, RAS, CAS and OE all go high after the OE phase. RAS stays high for `PRE_CYC` cycles with `req_ready` low, and the block then returns to idle.
- R6: With keep high, RAS stays low after the OE phase, CAS returns high, and `req_ready` is high. In FPM mode OE also returns high.
- R7: A request to the open row starts directly at the column-address phase and runs only the column, CAS and OE phases.
- R8: A request to a different row while a row is open first holds RAS, CAS and OE high for `PRE_CYC` cycles. It then runs the full sequence of R2 with the new row.
- R9: In EDO mode, OE stays low from the first OE phase for as long as the row remains open. This covers the open state and the column-address and CAS phases of later same-row accesses. The first access after a row is opened has OE high until its OE phase.
- R10: `req_ready` is high only in idle or while holding an open row. A request is taken on a clock edge where `req_valid` and `req_ready` are both high.
- R11: CAS falls only while RAS is low. The address lines do not change on the cycle RAS falls or on the cycle CAS falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| edo_mode | input | 1 | 1 selects extended-data-output behaviour |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can take a request |
| req_row | input | ROW_W | Requested row address |
| req_col | input | COL_W | Requested column address |
| req_keep | input | 1 | Keep the row open after this access |
| dram_addr | output | ADDR_W | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low (held high) |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq | input | DATA_W | Data returned by the DRAM |
| rd_valid | output | 1 | One-cycle pulse: rd_data is new |
| rd_data | output | DATA_W | Captured read word |

## Verification
Two events can fall in the same cycle: the read-data pulse of one access and the acceptance of the next same-row request. That cycle is the first cycle of the open-row state. The bench provokes it by presenting each keep-open request as soon as the previous one is taken. The cycle-accurate reference then expects `rd_valid` with the old word, `req_ready` high, and on the following cycle the column phase of the new access. In EDO runs the same cycle also checks that OE stays low while the next column begins.

// File: rtl/dram_page_rd_pkg.sv
`timescale 1ns/1ps
package dram_page_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_RAS,
    ST_COL,
    ST_CAS,
    ST_OE,
    ST_OPEN,
    ST_PRE
  } seq_st_t;
endpackage

// File: rtl/dram_rd_tmr.sv
`timescale 1ns/1ps
module dram_rd_tmr #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= load_val;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expire = (cnt_q == '0);
endmodule

// File: rtl/dram_rd_cap.sv
`timescale 1ns/1ps
module dram_rd_cap #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic [DATA_W-1:0] dq,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= sample;
      if (sample) rd_data <= dq;
    end
  end
endmodule

// File: rtl/dram_rd_ctrl.sv
`timescale 1ns/1ps
module dram_rd_ctrl
  import dram_page_rd_pkg::*;
#(
  parameter int ROW_W     = 8,
  parameter int COL_W     = 8,
  parameter int ADDR_W    = 8,
  parameter int CNT_W     = 2,
  parameter int PHASE_CYC = 2,
  parameter int PRE_CYC   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              edo_mode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_keep,
  input  logic              tmr_exp,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_val,
  output logic [ADDR_W-1:0] addr,
  output logic              ras_n,
  output logic              cas_n,
  output logic              oe_n,
  output logic              we_n,
  output logic              sample
);
  localparam logic [CNT_W-1:0] PH_M1  = CNT_W'(PHASE_CYC - 1);
  localparam logic [CNT_W-1:0] PRE_M1 = CNT_W'(PRE_CYC - 1);

  seq_st_t          st_q, st_nxt;
  logic [ROW_W-1:0] row_q, open_row_q;
  logic [COL_W-1:0] col_q;
  logic             keep_q, pend_q, oe_hold_q;
  logic             take, row_hit;

  assign req_ready = (st_q == ST_IDLE) || (st_q == ST_OPEN);
  assign take      = req_valid && req_ready;
  assign row_hit   = (req_row == open_row_q);

  always_comb begin
    st_nxt   = st_q;
    tmr_load = 1'b0;
    tmr_val  = PH_M1;
    case (st_q)
      ST_IDLE: if (req_valid) begin st_nxt = ST_ROW; tmr_load = 1'b1; end
      ST_ROW:  if (tmr_exp) begin st_nxt = ST_RAS; tmr_load = 1'b1; end
      ST_RAS:  if (tmr_exp) begin st_nxt = ST_COL; tmr_load = 1'b1; end
      ST_COL:  if (tmr_exp) begin st_nxt = ST_CAS; tmr_load = 1'b1; end
      ST_CAS:  if (tmr_exp) begin st_nxt = ST_OE;  tmr_load = 1'b1; end
      ST_OE: if (tmr_exp) begin
        tmr_load = 1'b1;
        if (keep_q) st_nxt = ST_OPEN;
        else begin st_nxt = ST_PRE; tmr_val = PRE_M1; end
      end
      ST_OPEN: if (req_valid) begin
        tmr_load = 1'b1;
        if (row_hit) st_nxt = ST_COL;
        else begin st_nxt = ST_PRE; tmr_val = PRE_M1; end
      end
      ST_PRE: if (tmr_exp) begin
        if (pend_q) begin st_nxt = ST_ROW; tmr_load = 1'b1; end
        else st_nxt = ST_IDLE;
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      row_q      <= '0;
      col_q      <= '0;
      open_row_q <= '0;
      keep_q     <= 1'b0;
      pend_q     <= 1'b0;
      oe_hold_q  <= 1'b0;
    end else begin
      st_q <= st_nxt;
      if (take) begin
        row_q  <= req_row;
        col_q  <= req_col;
        keep_q <= req_keep;
      end
      if (st_q == ST_RAS && tmr_exp) open_row_q <= row_q;
      if (st_q == ST_OPEN && req_valid && !row_hit) pend_q <= 1'b1;
      else if (st_q == ST_PRE && tmr_exp)          pend_q <= 1'b0;
      if (st_nxt == ST_PRE)                        oe_hold_q <= 1'b0;
      else if (st_q == ST_CAS && tmr_exp && edo_mode) oe_hold_q <= 1'b1;
    end
  end

  assign addr   = (st_q == ST_ROW || st_q == ST_RAS || st_q == ST_IDLE || st_q == ST_PRE)
                  ? ADDR_W'(row_q) : ADDR_W'(col_q);
  assign ras_n  = (st_q == ST_IDLE) || (st_q == ST_ROW) || (st_q == ST_PRE);
  assign cas_n  = !((st_q == ST_CAS) || (st_q == ST_OE));
  assign oe_n   = !((st_q == ST_OE) || oe_hold_q);
  assign we_n   = 1'b1;
  assign sample = (st_q == ST_OE) && tmr_exp;
endmodule

// File: rtl/dram_page_rd.sv
`timescale 1ns/1ps
module dram_page_rd #(
  parameter int ROW_W     = 8,
  parameter int COL_W     = 8,
  parameter int DATA_W    = 16,
  parameter int PHASE_CYC = 2,
  parameter int PRE_CYC   = 3,
  localparam int ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              edo_mode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_keep,
  output logic [ADDR_W-1:0] dram_addr,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  input  logic [DATA_W-1:0] dram_dq,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  localparam int MAX_CYC = (PHASE_CYC > PRE_CYC) ? PHASE_CYC : PRE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic             tmr_load, tmr_exp, sample;
  logic [CNT_W-1:0] tmr_val;

  dram_rd_tmr #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expire(tmr_exp)
  );

  dram_rd_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .PHASE_CYC(PHASE_CYC), .PRE_CYC(PRE_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .edo_mode(edo_mode),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_col(req_col), .req_keep(req_keep),
    .tmr_exp(tmr_exp), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .addr(dram_addr), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
    .oe_n(dram_oe_n), .we_n(dram_we_n), .sample(sample)
  );

  dram_rd_cap #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .sample(sample), .dq(dram_dq),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: rtl/dram_page_rd_chk.sv
`timescale 1ns/1ps
module dram_page_rd_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic [ADDR_W-1:0] dram_addr,
  input logic              dram_ras_n,
  input logic              dram_cas_n,
  input logic              dram_oe_n,
  input logic              rd_valid
);
  // R11
  cas_under_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !dram_ras_n);
  // R11
  ras_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> $stable(dram_addr));
  // R11
  cas_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_cas_n) |-> $stable(dram_addr));
  // R4
  rdv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  // R10
  ready_cas_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> dram_cas_n);
  // R5
  close_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_ras_n) |-> !req_ready);
  // R9
  oe_needs_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_oe_n |-> !dram_ras_n);
endmodule

bind dram_page_rd dram_page_rd_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .dram_addr(dram_addr),
  .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_oe_n(dram_oe_n),
  .rd_valid(rd_valid)
);

// File: tb/dram_page_rd_tb.sv
`timescale 1ns/1ps
module dram_page_rd_tb;
  localparam int RW = 8, CW = 8, DW = 16, PH = 2, PRE = 3;

  typedef struct {
    bit ras, cas, oe, rdy, rdv, ca;
    logic [7:0] a;
    logic [15:0] d;
    string rq;
  } vec_t;

  logic clk = 1'b0, rst_n = 1'b0, edo_mode = 1'b0;
  logic req_valid = 1'b0, req_keep = 1'b0;
  logic [RW-1:0] req_row = '0;
  logic [CW-1:0] req_col = '0;
  logic req_ready, dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, rd_valid;
  logic [7:0] dram_addr;
  logic [DW-1:0] dram_dq, rd_data;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  dram_page_rd #(.ROW_W(RW), .COL_W(CW), .DATA_W(DW), .PHASE_CYC(PH), .PRE_CYC(PRE)) u_dut (
    .clk(clk), .rst_n(rst_n), .edo_mode(edo_mode), .req_valid(req_valid),
    .req_ready(req_ready), .req_row(req_row), .req_col(req_col), .req_keep(req_keep),
    .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq(dram_dq),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  function automatic logic [15:0] pat(logic [7:0] r, logic [7:0] c);
    return {r, c} ^ 16'h5A3C;
  endfunction

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", rq, what, act, exp, $time);
    end
  endtask

  // Behavioural DRAM: latches row/column on strobe falls, drives data under OE
  logic [7:0] lat_row = '0, lat_col = '0;
  always @(negedge dram_ras_n) lat_row = dram_addr;
  always @(negedge dram_cas_n) begin
    lat_col = dram_addr;
    chk(!dram_ras_n, "R11", "CAS fell with RAS high", dram_ras_n, 0);
  end
  assign dram_dq = (!dram_oe_n && !dram_ras_n && (edo_mode || !dram_cas_n))
                   ? pat(lat_row, lat_col) : 16'hDEAD;

  // Reference model state
  vec_t q[$];
  bit m_open = 0, m_hold = 0;
  logic [7:0] m_row = '0;

  task automatic push(bit ras, bit cas, bit oe, bit rdy, bit rdv, bit ca,
                      logic [7:0] a, logic [15:0] d, string rq, int n);
    vec_t v;
    v.ras = ras; v.cas = cas; v.oe = oe; v.rdy = rdy; v.rdv = rdv; v.ca = ca;
    v.a = a; v.d = d; v.rq = rq;
    for (int i = 0; i < n; i++) q.push_back(v);
  endtask

  task automatic accept(logic [7:0] r, logic [7:0] c, bit k);
    bit oeh;
    if (m_open && r == m_row) begin
      oeh = m_hold;
    end else begin
      if (m_open) push(1, 1, 1, 0, 0, 0, 0, 0, "R8", PRE);
      oeh = 0;
      m_hold = 0;
      push(1, 1, 1, 0, 0, 1, r, 0, "R2", PH);
      push(0, 1, 1, 0, 0, 1, r, 0, "R2", PH);
    end
    push(0, 1, !oeh, 0, 0, 1, c, 0, oeh ? "R9" : "R7", PH);
    push(0, 0, !oeh, 0, 0, 1, c, 0, oeh ? "R9" : "R2", PH);
    push(0, 0, 0, 0, 0, 1, c, 0, "R2", PH);
    if (edo_mode) m_hold = 1;
    if (k) begin
      push(0, 1, !m_hold, 1, 1, 0, 0, pat(r, c), "R6", 1);
      m_open = 1; m_row = r;
    end else begin
      push(1, 1, 1, 0, 1, 0, 0, pat(r, c), "R5", 1);
      push(1, 1, 1, 0, 0, 0, 0, 0, "R5", PRE - 1);
      m_open = 0; m_hold = 0;
    end
  endtask

  initial begin
    @(posedge rst_n);
    forever begin
      vec_t e;
      @(negedge clk); #0.5;
      if (q.size() != 0) e = q.pop_front();
      else begin
        e.ras = !m_open; e.cas = 1; e.oe = !(m_open && m_hold); e.rdy = 1;
        e.rdv = 0; e.ca = 0; e.a = 0; e.d = 0; e.rq = m_open ? "R6" : "R5";
      end
      chk(dram_ras_n == e.ras, e.rq, "ras_n", dram_ras_n, e.ras);
      chk(dram_cas_n == e.cas, e.rq, "cas_n", dram_cas_n, e.cas);
      chk(dram_oe_n == e.oe, e.rq, "oe_n", dram_oe_n, e.oe);
      chk(dram_we_n == 1'b1, "R3", "we_n", dram_we_n, 1);
      chk(req_ready == e.rdy, "R10", "req_ready", req_ready, e.rdy);
      chk(rd_valid == e.rdv, "R4", "rd_valid", rd_valid, e.rdv);
      if (e.ca) chk(dram_addr == e.a, e.rq, "addr", dram_addr, e.a);
      if (e.rdv) chk(rd_data == e.d, "R4", "rd_data", rd_data, e.d);
      if (e.rdy && req_valid) accept(req_row, req_col, req_keep);
    end
  end

  task automatic send(logic [7:0] r, logic [7:0] c, bit k);
    @(negedge clk); #0.2;
    req_valid = 1; req_row = r; req_col = c; req_keep = k;
    while (!req_ready) begin @(negedge clk); #0.2; end
    @(posedge clk); #0.2;
    req_valid = 0;
  endtask

  task automatic run_tests();
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(dram_ras_n && dram_cas_n && dram_oe_n && dram_we_n, "R1", "strobes in reset",
        {dram_ras_n, dram_cas_n, dram_oe_n, dram_we_n}, 4'hF);
    chk(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
    chk(rd_valid == 1'b0, "R1", "rd_valid in reset", rd_valid, 0);
    #0.2 rst_n = 1;
    // single read, then page hits and a miss (FPM)
    send(8'd5, 8'd3, 0);
    send(8'd9, 8'd1, 1);
    send(8'd9, 8'd2, 1);
    send(8'd9, 8'd7, 1);
    send(8'd12, 8'd4, 0);
    repeat (20) @(negedge clk);
    // EDO variant
    #0.2 edo_mode = 1;
    send(8'd3, 8'd10, 1);
    send(8'd3, 8'd11, 1);
    send(8'd6, 8'd0, 1);
    send(8'd6, 8'd255, 1);
    send(8'd6, 8'd128, 0);
    repeat (20) @(negedge clk);
    // FPM again, boundary addresses, miss from an open row
    #0.2 edo_mode = 0;
    send(8'd0, 8'd0, 1);
    send(8'd255, 8'd255, 0);
    repeat (20) @(negedge clk);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not finish");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule